// File: doc/BRIEF.md
# Parallel DAC Write-Cycle Sequencer

This block sits on the host side of a multi-channel parallel-input DAC. It turns channel update commands into correctly timed bus cycles. Commands arrive on a valid/ready interface. Each command carries a channel number, a data word and an update flag. For every command the sequencer places the channel address and the data on the bus, lowers chip select and write together for one strobe pulse, then raises them and holds the bus for a short interval.

Commands without the update flag only fill the converter's input latches, so a batch of channels can be loaded back to back. When a command has the update flag set, its write is followed by one load pulse, which moves every input latch to the outputs at the same moment. The load pulse falls only after a programmed gap from the rise of chip select, so the converter's output deglitcher sees steady data.

A separate clear request lowers the clear line for a programmed time. No write cycle overlaps that time. Every interval is given in nanoseconds together with the clock period, and is rounded up to whole clock cycles.

Top module: `dac_wr_seq`

## Requirements
- R1: After reset, chip select, write, load and clear are all high (inactive), and cmd_ready is high.
- R2: A command is accepted on a rising clock edge where cmd_valid and cmd_ready are both high. dac_addr takes cmd_chan and dac_data takes cmd_data, as plain binary with bit 0 as the LSB. Both keep those values until the next accepted command.
- R3: For every write, dac_cs_n and dac_wr_n fall in the same cycle and rise in the same cycle. They stay low for exactly ceil(PULSE_NS/CLK_NS) cycles, which is 3 at the defaults.
- R4: dac_addr and dac_data do not change while the strobes are low, nor in the cycle in which the strobes rise.
- R5: cmd_ready is low from the cycle after acceptance until the hold interval ends. At the defaults this is 5 cycles for a write without the update flag.
- R6: A command with the update flag produces one load pulse on dac_load_n. The pulse is ceil(PULSE_NS/CLK_NS) cycles low. Its falling edge comes HOLD_CYC + GAP_CYC cycles after chip select rises, which is 3 cycles or 60 ns at the defaults. The load pulse never overlaps a low write strobe. At the defaults cmd_ready stays low for 10 cycles for such a command.
- R7: A command without the update flag produces no load pulse. A batch of several writes followed by one flagged write yields exactly one load pulse.
- R8: A one-cycle clr_req pulse in idle drives dac_clear_n low for exactly ceil(CLEAR_NS/CLK_NS) cycles, which is 15 at the defaults. While dac_clear_n is low, no write strobe is low and cmd_ready is low.
- R9: A clr_req that arrives during a write cycle is remembered. The clear pulse starts only after that write, and its load pulse if one was requested, has finished.
- R10: If clr_req and cmd_valid are high in the same idle cycle, the clear starts first. The command is accepted only after the clear pulse has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer can accept a command |
| cmd_chan | input | CH_W | Target channel |
| cmd_data | input | DATA_W | Code for the channel |
| cmd_load | input | 1 | Issue a global load after this write |
| clr_req | input | 1 | Request a clear pulse |
| dac_cs_n | output | 1 | Chip select, active low |
| dac_wr_n | output | 1 | Write strobe, active low |
| dac_addr | output | CH_W | Channel address bus |
| dac_data | output | DATA_W | Data bus |
| dac_load_n | output | 1 | Global load strobe, active low |
| dac_clear_n | output | 1 | Clear line, active low |

## Verification
Two things can land in the same clock edge: the acceptance of a new command and the acceptance of a clear request. The bench raises clr_req and cmd_valid together on an idle cycle. It then judges the clear pulse length, and checks that the write strobe starts only after the clear line has risen, with the held command's address and data. The second collision is a clear request raised while a flagged write is in progress. There the bench checks that the write and its load pulse complete first, and that the clear pulse starts afterwards at its full length.

// File: rtl/dac_wr_seq.sv
`timescale 1ns/1ps
module dac_wr_seq #(
  parameter int CH_W        = 3,
  parameter int DATA_W      = 13,
  parameter int CLK_NS      = 20,
  parameter int PULSE_NS    = 50,
  parameter int LOAD_GAP_NS = 50,
  parameter int CLEAR_NS    = 300,
  parameter int SETUP_CYC   = 1,
  parameter int HOLD_CYC    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CH_W-1:0]   cmd_chan,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              cmd_load,
  input  logic              clr_req,
  output logic              dac_cs_n,
  output logic              dac_wr_n,
  output logic [CH_W-1:0]   dac_addr,
  output logic [DATA_W-1:0] dac_data,
  output logic              dac_load_n,
  output logic              dac_clear_n
);
  localparam int PULSE_RAW = (PULSE_NS + CLK_NS - 1) / CLK_NS;
  localparam int PULSE_CYC = (PULSE_RAW < 1) ? 1 : PULSE_RAW;
  localparam int GAP_RAW   = (LOAD_GAP_NS + CLK_NS - 1) / CLK_NS - HOLD_CYC;
  localparam int GAP_CYC   = (GAP_RAW < 1) ? 1 : GAP_RAW;
  localparam int CLR_RAW   = (CLEAR_NS + CLK_NS - 1) / CLK_NS;
  localparam int CLEAR_CYC = (CLR_RAW < 1) ? 1 : CLR_RAW;
  localparam int CNT_W     = $clog2(CLEAR_CYC + PULSE_CYC + GAP_CYC + SETUP_CYC + HOLD_CYC + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_STROBE, S_HOLD, S_GAP, S_LOAD, S_CLEAR
  } state_t;

  state_t           st;
  logic [CNT_W-1:0] cnt;
  logic             load_pend;
  logic             clr_pend;

  assign cmd_ready   = (st == S_IDLE) && !clr_pend && !clr_req;
  assign dac_cs_n    = (st != S_STROBE);
  assign dac_wr_n    = (st != S_STROBE);
  assign dac_load_n  = (st != S_LOAD);
  assign dac_clear_n = (st != S_CLEAR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      load_pend <= 1'b0;
      clr_pend  <= 1'b0;
      dac_addr  <= '0;
      dac_data  <= '0;
    end else begin
      clr_pend <= clr_pend | clr_req;
      if (st != S_IDLE && cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        case (st)
          S_IDLE: begin
            if (clr_req || clr_pend) begin
              st       <= S_CLEAR;
              cnt      <= CNT_W'(CLEAR_CYC - 1);
              clr_pend <= 1'b0;
            end else if (cmd_valid) begin
              st        <= S_SETUP;
              cnt       <= CNT_W'(SETUP_CYC - 1);
              dac_addr  <= cmd_chan;
              dac_data  <= cmd_data;
              load_pend <= cmd_load;
            end
          end
          S_SETUP: begin
            st  <= S_STROBE;
            cnt <= CNT_W'(PULSE_CYC - 1);
          end
          S_STROBE: begin
            st  <= S_HOLD;
            cnt <= CNT_W'(HOLD_CYC - 1);
          end
          S_HOLD: begin
            if (load_pend) begin
              st  <= S_GAP;
              cnt <= CNT_W'(GAP_CYC - 1);
            end else begin
              st <= S_IDLE;
            end
          end
          S_GAP: begin
            st  <= S_LOAD;
            cnt <= CNT_W'(PULSE_CYC - 1);
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  logic [CNT_W-1:0] wr_run, load_run, clr_run, cs_high;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_run   <= '0;
      load_run <= '0;
      clr_run  <= '0;
      cs_high  <= '1;
    end else begin
      wr_run   <= dac_wr_n    ? '0 : ((wr_run   == '1) ? wr_run   : wr_run   + 1'b1);
      load_run <= dac_load_n  ? '0 : ((load_run == '1) ? load_run : load_run + 1'b1);
      clr_run  <= dac_clear_n ? '0 : ((clr_run  == '1) ? clr_run  : clr_run  + 1'b1);
      cs_high  <= !dac_cs_n   ? '0 : ((cs_high  == '1) ? cs_high  : cs_high  + 1'b1);
    end
  end

  p_wr_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_wr_n) |-> wr_run == CNT_W'(PULSE_CYC));

  p_bus_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!dac_wr_n && $past(!dac_wr_n)) |-> ($stable(dac_addr) && $stable(dac_data)));

  p_bus_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_wr_n) |-> ($stable(dac_addr) && $stable(dac_data)));

  p_ready_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_wr_n |-> !cmd_ready);

  p_load_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_load_n) |-> load_run == CNT_W'(PULSE_CYC));

  p_load_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_load_n) |-> cs_high >= CNT_W'(HOLD_CYC + GAP_CYC));

  p_load_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_load_n |-> (dac_wr_n && dac_cs_n));

  p_clear_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_clear_n) |-> clr_run == CNT_W'(CLEAR_CYC));

  p_clear_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_clear_n |-> (dac_wr_n && dac_load_n && !cmd_ready));
endmodule

// File: tb/dac_wr_seq_tb.sv
`timescale 1ns/1ps
module dac_wr_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_chan = '0;
  logic [12:0] cmd_data = '0;
  logic        cmd_load = 1'b0;
  logic        clr_req = 1'b0;
  logic        dac_cs_n, dac_wr_n, dac_load_n, dac_clear_n;
  logic [2:0]  dac_addr;
  logic [12:0] dac_data;

  always #10 clk = ~clk;

  dac_wr_seq dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_chan(cmd_chan), .cmd_data(cmd_data), .cmd_load(cmd_load),
    .clr_req(clr_req),
    .dac_cs_n(dac_cs_n), .dac_wr_n(dac_wr_n),
    .dac_addr(dac_addr), .dac_data(dac_data),
    .dac_load_n(dac_load_n), .dac_clear_n(dac_clear_n)
  );

  localparam int EXP_PULSE = 3;
  localparam int EXP_GAP   = 3;
  localparam int EXP_CLEAR = 15;
  localparam int EXP_BUSY  = 5;
  localparam int EXP_BUSYL = 10;

  localparam int NV = 8;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 3'd0, 13'h0000},
    {1'b0, 3'd7, 13'h1FFF},
    {1'b1, 3'd5, 13'h1000},
    {1'b0, 3'd1, 13'h0AAA},
    {1'b0, 3'd2, 13'h1555},
    {1'b0, 3'd6, 13'h0FFF},
    {1'b1, 3'd3, 13'h0001},
    {1'b1, 3'd4, 13'h13D9}
  };

  int checks = 0, errors = 0, cyc = 0;
  int wr_run = 0, wr_count = 0, last_wr_len = 0, wr_start = 0, stab_err = 0, pair_err = 0;
  int ld_run = 0, ld_count = 0, last_ld_len = 0, last_gap = 0, ld_end = 0, overlap_err = 0;
  int clr_run = 0, clr_count = 0, last_clr_len = 0, clr_start = 0, clr_end = 0, clr_err = 0;
  int cs_hi = 0;
  logic [2:0]  first_addr, last_addr;
  logic [12:0] first_data, last_data;
  logic        done = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (dac_cs_n != dac_wr_n) pair_err++;
      if (!dac_wr_n) begin
        if (wr_run == 0) begin
          first_addr = dac_addr; first_data = dac_data; wr_start = cyc;
        end else if (dac_addr != first_addr || dac_data != first_data) stab_err++;
        wr_run++;
      end else if (wr_run > 0) begin
        if (dac_addr != first_addr || dac_data != first_data) stab_err++;
        last_wr_len = wr_run; last_addr = first_addr; last_data = first_data;
        wr_count++; wr_run = 0;
      end
      if (!dac_load_n) begin
        if (ld_run == 0) last_gap = cs_hi;
        ld_run++;
        if (!dac_wr_n) overlap_err++;
      end else if (ld_run > 0) begin
        last_ld_len = ld_run; ld_count++; ld_end = cyc; ld_run = 0;
      end
      if (!dac_clear_n) begin
        if (clr_run == 0) clr_start = cyc;
        clr_run++;
        if (!dac_wr_n || cmd_ready) clr_err++;
      end else if (clr_run > 0) begin
        last_clr_len = clr_run; clr_count++; clr_end = cyc; clr_run = 0;
      end
      cs_hi = dac_cs_n ? cs_hi + 1 : 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] ch, input logic [12:0] d, input logic ld);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_chan = ch; cmd_data = d; cmd_load = ld; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!cmd_ready) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int busy, wr0, ld0, loads;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 cs_n", dac_cs_n, 1); chk("R1 wr_n", dac_wr_n, 1);
    chk("R1 load_n", dac_load_n, 1); chk("R1 clear_n", dac_clear_n, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", cmd_ready, 1);

    loads = 0;
    for (int i = 0; i < NV; i++) begin
      logic ld;
      ld = VEC[i][16];
      wr0 = wr_count; ld0 = ld_count;
      issue(VEC[i][15:13], VEC[i][12:0], ld);
      wait_ready(busy);
      @(negedge clk);
      chk("R2 addr", last_addr, VEC[i][15:13]);
      chk("R2 data", last_data, VEC[i][12:0]);
      chk("R2 held addr", dac_addr, VEC[i][15:13]);
      chk("R3 write count", wr_count - wr0, 1);
      chk("R3 strobe width", last_wr_len, EXP_PULSE);
      chk("R5 busy cycles", busy, ld ? EXP_BUSYL : EXP_BUSY);
      chk("R7 load pulses", ld_count - ld0, ld ? 1 : 0);
      if (ld) begin
        loads++;
        chk("R6 load width", last_ld_len, EXP_PULSE);
        chk("R6 load gap", last_gap, EXP_GAP);
      end
    end
    chk("R7 batch total loads", ld_count, loads);
    chk("R3 cs/wr paired", pair_err, 0);
    chk("R4 bus stable", stab_err, 0);
    chk("R6 no overlap", overlap_err, 0);

    // R8: clear from idle
    @(negedge clk);
    clr_req = 1'b1;
    @(negedge clk);
    clr_req = 1'b0;
    chk("R8 clear active", dac_clear_n, 0);
    chk("R8 ready low", cmd_ready, 0);
    wait_ready(busy);
    @(negedge clk);
    chk("R8 clear width", last_clr_len, EXP_CLEAR);
    chk("R8 quiet during clear", clr_err, 0);

    // R9: clear requested mid-write
    wr0 = wr_count; ld0 = ld_count;
    issue(3'd6, 13'h0321, 1'b1);
    clr_req = 1'b1;
    @(negedge clk);
    clr_req = 1'b0;
    chk("R9 no early clear", dac_clear_n, 1);
    wait_ready(busy);
    @(negedge clk);
    chk("R9 write done", wr_count - wr0, 1);
    chk("R9 load done", ld_count - ld0, 1);
    chk("R9 clear after load", (clr_start >= ld_end) ? 1 : 0, 1);
    chk("R9 clear width", last_clr_len, EXP_CLEAR);

    // R10: clear and command in the same cycle
    wr0 = wr_count;
    @(negedge clk);
    clr_req = 1'b1;
    cmd_chan = 3'd2; cmd_data = 13'h0123; cmd_load = 1'b0; cmd_valid = 1'b1;
    @(negedge clk);
    clr_req = 1'b0;
    chk("R10 clear first", dac_clear_n, 0);
    chk("R10 no write yet", wr_count - wr0, 0);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_ready(busy);
    @(negedge clk);
    chk("R10 write after clear", (wr_start > clr_end) ? 1 : 0, 1);
    chk("R10 addr", last_addr, 2);
    chk("R10 data", last_data, 13'h0123);
    chk("R10 clear width", last_clr_len, EXP_CLEAR);
    chk("R8 quiet total", clr_err, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule